// File: doc/BRIEF.md
# Dual-Window Threshold Compare Unit

This block grades every finished conversion result against a low/high window. Two windows are kept, and each channel is tied to one of them by a per-channel select bit. For each result the block returns two 2-bit codes one cycle later. The range code tells whether the value lay inside, below or above its window. The crossing code tells whether the value passed through the window's low bound in either direction since the previous result on the same channel. A sequencer can place both codes into the result word it stores.

Each channel also has a 2-bit event mode: off, outside window, or low-bound crossing. When the selected event happens, the channel's sticky flag is set. Software clears flags by writing ones. A single interrupt line is the OR of all flags whose channel has an active mode. Configuration uses a narrow register write port with word addresses 0 to 6.

Top module: `dual_window_cmp`

## Requirements
- R1: After reset, cmp_vld, cmp_range, cmp_cross, thr_flags and thr_irq are all 0, and no channel has a previous result.
- R2: Range code: 0 when low <= result <= high, 2 when result < low, 3 when result > high. The value 1 never appears.
- R3: Bit n of the write to address 4 (bits NCH-1:0) selects window 1 for channel n when 1 and window 0 when 0.
- R4: Writes to address 0 and 1 set the low bound of window 0 and 1. Writes to address 2 and 3 set the high bound of window 0 and 1. In each case the bound is taken from wr_data bits 15:4. A write takes effect for results that arrive in the following cycle or later.
- R5: Crossing code: 2 when the previous result on the channel was >= low and the current one is < low. 3 when the previous was < low and the current is >= low. 0 otherwise. The low bound is the one of the channel's current window. The first result on a channel after reset gives 0.
- R6: cmp_vld is high in the cycle after a valid result on a channel below NCH, and cmp_range and cmp_cross then belong to that result.
- R7: The write to address 5 sets channel n's mode from wr_data bits 3+2n+1:3+2n. Mode 1 sets flag n when the range code is non-zero. Mode 2 sets flag n when the crossing code is non-zero. Modes 0 and 3 never set a flag.
- R8: A write to address 6 clears every flag whose bit in wr_data is 1. If a flag is set and cleared in the same cycle, it ends set.
- R9: thr_irq equals the OR of thr_flags[n] over channels whose mode is 1 or 2.
- R10: A result whose channel index is NCH or higher is ignored. It gives no cmp_vld, sets no flag, and leaves the channel histories unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register word address |
| wr_data | input | 32 | Register write data |
| res_vld | input | 1 | Conversion result strobe |
| res_data | input | RW (12) | Conversion result |
| res_ch | input | CHW (4) | Channel of the result |
| cmp_vld | output | 1 | Codes below are valid |
| cmp_range | output | 2 | Range code |
| cmp_cross | output | 2 | Crossing code |
| thr_flags | output | NCH (12) | Sticky per-channel event flags |
| thr_irq | output | 1 | Combined threshold interrupt |

## Verification
The hardest case to reach is a crossing on one channel while other channels' results are interleaved in between, since the crossing depends on a history kept per channel. Equally hard is a channel whose window select or low bound changes between two of its results. The stimulus drives directed pairs at exactly low-1, low, high and high+1 on channels using both windows. It then runs a long random phase that mixes valid and out-of-range channel indices, values clustered around the bounds, and occasional writes to every register, including clears colliding with new events. A behavioural model in the bench follows all of this and is compared every cycle.

// File: rtl/dual_window_cmp.sv
module dual_window_cmp #(
  parameter int NCH  = 12,
  parameter int RW   = 12,
  parameter int AW   = 3,
  parameter int CHW  = $clog2(NCH + 1),
  parameter int TPOS = 4,
  parameter int MPOS = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [31:0]    wr_data,
  input  logic           res_vld,
  input  logic [RW-1:0]  res_data,
  input  logic [CHW-1:0] res_ch,
  output logic           cmp_vld,
  output logic [1:0]     cmp_range,
  output logic [1:0]     cmp_cross,
  output logic [NCH-1:0] thr_flags,
  output logic           thr_irq
);
  localparam logic [AW-1:0] A_LO0 = 0, A_LO1 = 1, A_HI0 = 2, A_HI1 = 3;
  localparam logic [AW-1:0] A_SEL = 4, A_MODE = 5, A_CLR = 6;
  localparam logic [1:0] RNG_IN = 2'd0, RNG_BELOW = 2'd2, RNG_ABOVE = 2'd3;
  localparam logic [1:0] X_NONE = 2'd0, X_DOWN = 2'd2, X_UP = 2'd3;

  logic [RW-1:0]    lo_q [2];
  logic [RW-1:0]    hi_q [2];
  logic [NCH-1:0]   sel_q;
  logic [2*NCH-1:0] mode_q;
  logic [RW-1:0]    prev_q [NCH];
  logic [NCH-1:0]   seen_q;
  logic [NCH-1:0]   act;

  logic           ch_ok, win, seen, hit;
  logic [RW-1:0]  lo, hi, prev;
  logic [1:0]     rng, crs, mode;
  logic [NCH-1:0] flags_d;

  logic unused_wr;
  assign unused_wr = ^wr_data;

  assign ch_ok = res_vld && (32'(res_ch) < NCH);
  assign win   = ch_ok ? sel_q[res_ch] : 1'b0;
  assign lo    = lo_q[win];
  assign hi    = hi_q[win];
  assign seen  = ch_ok ? seen_q[res_ch] : 1'b0;
  assign prev  = ch_ok ? prev_q[res_ch] : '0;
  assign mode  = ch_ok ? mode_q[2*res_ch +: 2] : 2'd0;

  assign rng = (res_data < lo) ? RNG_BELOW : (res_data > hi) ? RNG_ABOVE : RNG_IN;
  assign crs = !seen ? X_NONE :
               ((prev >= lo) && (res_data < lo)) ? X_DOWN :
               ((prev < lo) && (res_data >= lo)) ? X_UP : X_NONE;
  assign hit = ch_ok && (((mode == 2'd1) && (rng != RNG_IN)) ||
                         ((mode == 2'd2) && (crs != X_NONE)));

  always_comb begin
    flags_d = thr_flags;
    if (wr_en && wr_addr == A_CLR) flags_d = flags_d & ~wr_data[NCH-1:0];
    if (hit) flags_d[res_ch] = 1'b1;
  end

  for (genvar n = 0; n < NCH; n++) begin : g_act
    assign act[n] = (mode_q[2*n +: 2] == 2'd1) || (mode_q[2*n +: 2] == 2'd2);
  end
  assign thr_irq = |(thr_flags & act);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q[0] <= '0; lo_q[1] <= '0; hi_q[0] <= '0; hi_q[1] <= '0;
      sel_q <= '0; mode_q <= '0; seen_q <= '0; thr_flags <= '0;
      cmp_vld <= 1'b0; cmp_range <= RNG_IN; cmp_cross <= X_NONE;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_LO0:  lo_q[0] <= wr_data[TPOS +: RW];
          A_LO1:  lo_q[1] <= wr_data[TPOS +: RW];
          A_HI0:  hi_q[0] <= wr_data[TPOS +: RW];
          A_HI1:  hi_q[1] <= wr_data[TPOS +: RW];
          A_SEL:  sel_q   <= wr_data[NCH-1:0];
          A_MODE: mode_q  <= wr_data[MPOS +: 2*NCH];
          default: ;
        endcase
      end
      thr_flags <= flags_d;
      cmp_vld   <= ch_ok;
      if (ch_ok) begin
        cmp_range      <= rng;
        cmp_cross      <= crs;
        seen_q[res_ch] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ch_ok) prev_q[res_ch] <= res_data;
  end

  a_r2_range_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld |-> cmp_range != 2'd1);
  a_r5_cross_code_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_vld |-> cmp_cross != 2'd1);
  a_r6_vld_after_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_vld && (32'(res_ch) < NCH) |=> cmp_vld);
  a_r10_bad_channel_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    !res_vld || (32'(res_ch) >= NCH) |=> !cmp_vld);
  a_r8_flags_fall_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CLR) == 1'b0 |=> (thr_flags & ~$past(thr_flags)) == thr_flags - (thr_flags & $past(thr_flags)) && ($past(thr_flags) & ~thr_flags) == '0);
  a_r9_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    thr_irq |-> thr_flags != '0);
endmodule

// File: tb/dual_window_cmp_tb_top.sv
module dual_window_cmp_tb_top;
  localparam int NCH = 12, RW = 12, AW = 3, CHW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0; logic [AW-1:0] wr_addr = '0; logic [31:0] wr_data = '0;
  logic res_vld = 1'b0; logic [RW-1:0] res_data = '0; logic [CHW-1:0] res_ch = '0;
  logic cmp_vld, thr_irq; logic [1:0] cmp_range, cmp_cross; logic [NCH-1:0] thr_flags;

  int checks = 0, errors = 0;
  bit checking = 0;

  dual_window_cmp dut_i (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .res_vld(res_vld), .res_data(res_data), .res_ch(res_ch),
    .cmp_vld(cmp_vld), .cmp_range(cmp_range), .cmp_cross(cmp_cross),
    .thr_flags(thr_flags), .thr_irq(thr_irq));

  always #4 clk = ~clk;

  int lo[2], hi[2], prv[NCH];
  bit seen[NCH];
  bit [NCH-1:0] sel, flg;
  int md[NCH];
  bit e_vld; int e_rng, e_crs;

  always @(posedge clk) begin
    if (!rst_n) begin
      lo[0] = 0; lo[1] = 0; hi[0] = 0; hi[1] = 0; sel = '0; flg = '0; e_vld = 0;
      for (int n = 0; n < NCH; n++) begin md[n] = 0; seen[n] = 0; prv[n] = 0; end
    end else begin
      int c, v, l, h, r, x;
      bit ev;
      c = int'(res_ch); v = int'(res_data); ev = 0;
      e_vld = res_vld && c < NCH;
      if (e_vld) begin
        l = lo[sel[c]]; h = hi[sel[c]];
        r = (v < l) ? 2 : (v > h) ? 3 : 0;
        x = 0;
        if (seen[c] && prv[c] >= l && v < l) x = 2;
        if (seen[c] && prv[c] < l && v >= l) x = 3;
        e_rng = r; e_crs = x;
        ev = (md[c] == 1 && r != 0) || (md[c] == 2 && x != 0);
        seen[c] = 1; prv[c] = v;
      end
      if (wr_en) begin
        case (wr_addr)
          0: lo[0] = int'(wr_data[15:4]);
          1: lo[1] = int'(wr_data[15:4]);
          2: hi[0] = int'(wr_data[15:4]);
          3: hi[1] = int'(wr_data[15:4]);
          4: sel = wr_data[NCH-1:0];
          5: for (int n = 0; n < NCH; n++) md[n] = int'(wr_data[3+2*n +: 2]);
          6: flg = flg & ~wr_data[NCH-1:0];
          default: ;
        endcase
      end
      if (ev) flg[c] = 1'b1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (checking) begin
    bit ei;
    ei = 0;
    for (int n = 0; n < NCH; n++) if (flg[n] && (md[n] == 1 || md[n] == 2)) ei = 1;
    chk("R6 R10 cmp_vld", int'(cmp_vld), int'(e_vld));
    if (e_vld) begin
      chk("R2 R3 R4 range", int'(cmp_range), e_rng);
      chk("R5 cross", int'(cmp_cross), e_crs);
    end
    chk("R7 R8 flags", int'(thr_flags), int'(flg));
    chk("R9 irq", int'(thr_irq), int'(ei));
  end

  task automatic cyc(); @(negedge clk); wr_en = 0; res_vld = 0; endtask
  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); res_vld = 0; wr_en = 1; wr_addr = AW'(a); wr_data = d;
  endtask
  task automatic smp(int ch, int v);
    @(negedge clk); wr_en = 0; res_vld = 1; res_ch = CHW'(ch); res_data = RW'(v);
  endtask
  function automatic logic [31:0] modes(int m0, int m1, int m3, int m5, int m7);
    logic [31:0] d = '0;
    d[3+0 +: 2] = 2'(m0); d[3+2 +: 2] = 2'(m1); d[3+6 +: 2] = 2'(m3);
    d[3+10 +: 2] = 2'(m5); d[3+14 +: 2] = 2'(m7);
    return d;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 vld", int'(cmp_vld), 0); chk("R1 range", int'(cmp_range), 0);
    chk("R1 cross", int'(cmp_cross), 0); chk("R1 flags", int'(thr_flags), 0);
    chk("R1 irq", int'(thr_irq), 0);
    rst_n = 1; checking = 1;
    wr(0, 1000 << 4); wr(2, 3000 << 4); wr(1, 200 << 4); wr(3, 400 << 4);
    wr(4, 32'h088); wr(5, modes(1, 2, 1, 3, 2));
    smp(0, 1000); smp(0, 3000); smp(0, 999); smp(0, 3001); cyc();
    wr(6, 32'h1); cyc();
    smp(1, 1200); smp(2, 500); smp(1, 999); smp(2, 1500); smp(1, 1000); cyc();
    smp(3, 200); smp(3, 400); smp(3, 199); smp(3, 401); smp(7, 300); smp(7, 150);
    smp(7, 200); smp(5, 10); smp(5, 4000); smp(13, 5); smp(15, 4095);
    wr(6, 32'hFFF); cyc();
    smp(1, 900); wr(6, 32'h2); smp(1, 1100); wr(6, 32'h2); cyc();
    for (int i = 0; i < 6000; i++) begin
      int k;
      k = $urandom_range(0, 19);
      if (k == 0) wr($urandom_range(0, 7), $urandom);
      else if (k == 1) wr(5, $urandom);
      else if (k < 4) begin
        @(negedge clk); wr_en = 1; wr_addr = 6; wr_data = $urandom;
        res_vld = 1; res_ch = CHW'($urandom_range(0, 15));
        res_data = RW'($urandom);
      end else if (k < 7) cyc();
      else smp($urandom_range(0, 15),
               (k < 12) ? int'(lo[$urandom_range(0, 1)]) + $urandom_range(0, 2) - 1
                        : int'($urandom_range(0, 4095)));
    end
    cyc(); cyc();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule